// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary lock flags that two independent ports share. Each side reaches the bank through its own semaphore select, write enable, output enable, address and data lines. A side asks for a flag by writing 0 into data bit 0 and gives it back by writing 1. At most one side owns a flag at any time. When a side asks for a flag the other side already owns, the request is parked in that side's pending latch. Ownership then passes to it on the edge where the owner gives the flag back.

Flags read active low: an owned flag reads 0 on the owning side and 1 on the other side, and a free flag reads 1 on both sides. The value read is copied onto every bit of the data bus. It is frozen for as long as the read stays active, so software can run a set-then-test sequence without seeing the flag change under it. The bank is clocked and uses a synchronous active-low reset. The chip-enable input of each side selects a separate memory space. While a side's chip enable is active, that side's semaphore accesses are blocked.

Top module: `sem_bank_dual`

## Requirements
- R1: After reset every flag is free, and a read of any flag from either side returns 16'hFFFF.
- R2: Address bits [2:0] pick one of eight flags and all higher address bits are ignored. A write uses only data bit 0, and data bits [15:1] are ignored.
- R3: A write of 0 to a free flag makes the writing side its owner at that clock edge. That side then reads 16'h0000 and the other side reads 16'hFFFF.
- R4: A write of 0 from the side that does not own the flag changes no flag value: both sides keep reading as before, and the request stays pending.
- R5: When the owner writes 1, the flag passes at that edge to the other side if that side has a pending request. Otherwise the flag becomes free on both sides. An owner that writes 0 again, or writes nothing, keeps the flag.
- R6: If both sides request a free flag at the same edge, the left side is granted. A request made at an earlier edge always beats a later one.
- R7: A write takes effect only on an edge where semaphore select and write enable are low and chip enable is high. Any other combination leaves all flags unchanged.
- R8: A read starts on the first edge where semaphore select and output enable are low, write enable is high and chip enable is high. From that edge on, rdata holds the flag value as it was just before the edge, copied onto all 16 bits.
- R9: While the read conditions stay true, rdata does not change, even when the other side changes the flag. A new value appears only when a new read starts.
- R10: A write of 1 from the side that does not own the flag withdraws its pending request, so a later release by the owner leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left memory-space enable, active low; blocks semaphore access when low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address; bits [2:0] pick the flag |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left read data, flag copied onto all bits |
| r_ce_n | input | 1 | Right memory-space enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address; bits [2:0] pick the flag |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right read data, flag copied onto all bits |

## Verification
A write changes flag state at the edge where it is sampled. A read started on the next edge already sees the new value. A read started on the same edge as a write from the other side sees the old value. Read data becomes valid one edge after the read conditions are first driven, and it stays unchanged until the read ends. The bench drives inputs on the falling edge and updates its model on the rising edge. It compares read data only after the following falling edge. The frozen-read case is checked on each of several edges while the other side hands the flag over.

// File: rtl/sem_pkg.sv
// Package: shared types for the two-port semaphore bank.
// Assumes: exactly two sides, left and right.
package sem_pkg;

    // Owner of one flag
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one side's control lines into a write strobe, a read-active level,
// a flag index and a write bit.
// Assumes: all controls are active low and synchronous to clk. Chip enable
// active means another space is addressed, so semaphore access is blocked.
module sem_port_decode #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              ce_n,
    input  logic              sem_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_stb,
    output logic              rd_on,
    output logic [IDX_W-1:0]  idx,
    output logic              wbit
);

    logic unused_bits;

    // Decode access type from the control lines (R7, R8)
    always_comb begin
        wr_stb = !sem_n && !we_n && ce_n;
        rd_on  = !sem_n && !oe_n && we_n && ce_n;
    end

    // Flag index from the low address bits; data bit 0 only (R2)
    always_comb begin
        idx  = addr[IDX_W-1:0];
        wbit = wdata[0];
    end

    // Fold the ignored bits so that they are visibly consumed
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

endmodule

// File: rtl/sem_flag_cell.sv
// Module: sem_flag_cell
// One semaphore flag: a request latch per side plus an owner register.
// Assumes: the write strobes are already qualified for this flag. A latch
// value of 1 means no request.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wl,
    input  logic dl,
    input  logic wr,
    input  logic dr,
    output logic view_l,
    output logic view_r
);

    logic   req_l_n, req_r_n;
    logic   nreq_l_n, nreq_r_n;
    logic   want_l, want_r;
    owner_e owner, owner_nxt;

    // Next request latch values after this edge's writes
    always_comb begin
        nreq_l_n = wl ? dl : req_l_n;
        nreq_r_n = wr ? dr : req_r_n;
        want_l   = !nreq_l_n;
        want_r   = !nreq_r_n;
    end

    // Owner keeps the flag while requesting; else it goes to the waiter; left wins a tie
    always_comb begin
        unique case (owner)
            OWN_LEFT:  owner_nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
            OWN_RIGHT: owner_nxt = want_r ? OWN_RIGHT : (want_l ? OWN_LEFT  : OWN_NONE);
            default:   owner_nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
        endcase
    end

    // State registers with synchronous reset to free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l_n <= 1'b1;
            req_r_n <= 1'b1;
            owner   <= OWN_NONE;
        end else begin
            req_l_n <= nreq_l_n;
            req_r_n <= nreq_r_n;
            owner   <= owner_nxt;
        end
    end

    // Active-low view of the flag per side
    always_comb begin
        view_l = (owner != OWN_LEFT);
        view_r = (owner != OWN_RIGHT);
    end

    AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && !(wl && dl)) |=> (owner == OWN_LEFT)); // R5
    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && wl && dl && !req_r_n && !wr) |=> (owner == OWN_RIGHT)); // R5
    AST_PENDING_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_RIGHT && !(wr && dr)) |=> (owner == OWN_RIGHT)); // R4
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_NONE && wl && !dl && wr && !dr) |=> (owner == OWN_LEFT)); // R6
    AST_FREE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && wl && dl && req_r_n && !wr) |=> (owner == OWN_NONE)); // R10

endmodule

// File: rtl/sem_read_snap.sv
// Module: sem_read_snap
// Captures the selected flag on the first edge of a read and holds it
// until the read ends.
// Assumes: view bits are active low; rd_on is the decoded read level.
module sem_read_snap #(
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_on,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] view,
    output logic [DATA_W-1:0]    rdata
);

    logic rd_q;

    // Remember whether a read was active last cycle; capture on its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            rdata <= '1;
        end else begin
            rd_q <= rd_on;
            if (rd_on && !rd_q) begin
                rdata <= {DATA_W{view[idx]}};
            end
        end
    end

    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && rd_q) |=> $stable(rdata)); // R9
    AST_READ_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> (rdata == '0 || rdata == '1)); // R8

endmodule

// File: rtl/sem_bank_dual.sv
// Module: sem_bank_dual (top)
// Eight-flag hardware semaphore bank shared by a left and a right port.
// Assumes: both ports are synchronous to clk; reset is synchronous, active low.
module sem_bank_dual #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 16,
    parameter int NUM_FLAGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sem_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_sem_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic                 l_wr, l_rd, l_bit, r_wr, r_rd, r_bit;
    logic [IDX_W-1:0]     l_idx, r_idx;
    logic [NUM_FLAGS-1:0] view_l, view_r;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_l (
        .ce_n(l_ce_n), .sem_n(l_sem_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .addr(l_addr), .wdata(l_wdata),
        .wr_stb(l_wr), .rd_on(l_rd), .idx(l_idx), .wbit(l_bit)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_r (
        .ce_n(r_ce_n), .sem_n(r_sem_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .addr(r_addr), .wdata(r_wdata),
        .wr_stb(r_wr), .rd_on(r_rd), .idx(r_idx), .wbit(r_bit)
    );

    // One flag cell per address, each seeing only its own write strobes
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic wl_g, wr_g;
        assign wl_g = l_wr && (l_idx == IDX_W'(g));
        assign wr_g = r_wr && (r_idx == IDX_W'(g));
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .wl(wl_g), .dl(l_bit), .wr(wr_g), .dr(r_bit),
            .view_l(view_l[g]), .view_r(view_r[g])
        );
    end

    sem_read_snap #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_snap_l (
        .clk(clk), .rst_n(rst_n), .rd_on(l_rd), .idx(l_idx),
        .view(view_l), .rdata(l_rdata)
    );

    sem_read_snap #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_snap_r (
        .clk(clk), .rst_n(rst_n), .rd_on(r_rd), .idx(r_idx),
        .view(view_r), .rdata(r_rdata)
    );

    AST_NEVER_BOTH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((view_l | view_r) == '1)); // R6

endmodule

// File: tb/sim_sem_bank_dual.sv
module sim_sem_bank_dual;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          l_ce_n = 1, l_sem_n = 1, l_we_n = 1, l_oe_n = 1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          r_ce_n = 1, r_sem_n = 1, r_we_n = 1, r_oe_n = 1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Model: request latches (1 = idle) and owner (0 none, 1 left, 2 right)
    bit mreq_l [8];
    bit mreq_r [8];
    int mown   [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank_dual u0 (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic logic [DW-1:0] exp_rd(bit left, int i);
        bit v;
        v = left ? (mown[i] != 1) : (mown[i] != 2);
        return {DW{v}};
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin
            mreq_l[i] = 1; mreq_r[i] = 1; mown[i] = 0;
        end
    endfunction

    // Apply one edge of writes per the requirements (R2, R3-R7, R10)
    function automatic void model_edge();
        bit wl, wr, wantl, wantr;
        int il, ir;
        wl = !l_sem_n && !l_we_n && l_ce_n;
        wr = !r_sem_n && !r_we_n && r_ce_n;
        il = int'(l_addr[2:0]);
        ir = int'(r_addr[2:0]);
        if (wl) mreq_l[il] = l_wdata[0];
        if (wr) mreq_r[ir] = r_wdata[0];
        for (int i = 0; i < 8; i++) begin
            wantl = !mreq_l[i]; wantr = !mreq_r[i];
            if (mown[i] == 1 && wantl) mown[i] = 1;
            else if (mown[i] == 2 && wantr) mown[i] = 2;
            else if (mown[i] == 2) mown[i] = wantl ? 1 : 0;
            else if (mown[i] == 1) mown[i] = wantr ? 2 : 0;
            else mown[i] = wantl ? 1 : (wantr ? 2 : 0);
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_edge(); else model_reset();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_l();
        l_ce_n = 1; l_sem_n = 1; l_we_n = 1; l_oe_n = 1;
    endtask
    task automatic idle_r();
        r_ce_n = 1; r_sem_n = 1; r_we_n = 1; r_oe_n = 1;
    endtask

    task automatic wr_l(logic [AW-1:0] a, logic [DW-1:0] d);
        l_ce_n = 1; l_sem_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = a; l_wdata = d;
    endtask
    task automatic wr_r(logic [AW-1:0] a, logic [DW-1:0] d);
        r_ce_n = 1; r_sem_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = a; r_wdata = d;
    endtask
    task automatic rd_l(logic [AW-1:0] a);
        l_ce_n = 1; l_sem_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a;
    endtask
    task automatic rd_r(logic [AW-1:0] a);
        r_ce_n = 1; r_sem_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a;
    endtask

    // Read one flag from both sides at once and compare
    task automatic read_both(string req, int i, logic [AW-1:0] hi);
        logic [DW-1:0] el, er;
        el = exp_rd(1, i); er = exp_rd(0, i);
        rd_l({hi[AW-1:3], 3'(i)}); rd_r({hi[AW-1:3], 3'(i)});
        tick();
        chk(req, l_rdata, el);
        chk(req, r_rdata, er);
        idle_l(); idle_r();
        tick();
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 8; i++) read_both(req, i, AW'($urandom));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EA1));
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: all free after reset
        read_all("R1");

        // R3 + R2: left takes flag 3 using high address bits and junk data bits
        wr_l(15'h7FF3, 16'hFFFE); tick(); idle_l(); tick();
        read_both("R3", 3, 15'h1230);

        // R4: right requests owned flag 3, still reads 1; left keeps it
        wr_r(15'h0003, 16'h0000); tick(); idle_r(); tick();
        read_both("R4", 3, 15'h0000);

        // R9: right reading flag 3 during handoff stays frozen
        rd_r(15'h0003); tick();
        chk("R8", r_rdata, 16'hFFFF);
        wr_l(15'h0003, 16'h0001); tick(); idle_l();
        chk("R9", r_rdata, 16'hFFFF);
        tick();
        chk("R9", r_rdata, 16'hFFFF);
        idle_r(); tick();
        // R5: handoff took place
        read_both("R5", 3, 15'h0000);
        chk("R5", 16'(mown[3]), 16'd2);

        // R10: left requests, withdraws, right releases -> free
        wr_l(15'h0003, 16'h0000); tick();
        wr_l(15'h0003, 16'h0001); tick(); idle_l();
        wr_r(15'h0003, 16'h0001); tick(); idle_r(); tick();
        read_both("R10", 3, 15'h0000);

        // R6: simultaneous requests on free flag 6 -> left
        wr_l(15'h0006, 16'h0000); wr_r(15'h0006, 16'h0000); tick();
        idle_l(); idle_r(); tick();
        read_both("R6", 6, 15'h4000);

        // R6: earlier right request on flag 1 beats later left request
        wr_r(15'h0001, 16'h0000); tick();
        idle_r(); wr_l(15'h0001, 16'h0000); tick(); idle_l(); tick();
        read_both("R6", 1, 15'h0000);

        // R7: writes with chip enable active or select inactive are ignored
        l_ce_n = 0; l_sem_n = 0; l_we_n = 0; l_addr = 15'h0002; l_wdata = 16'h0; tick();
        l_ce_n = 1; l_sem_n = 1; tick(); idle_l(); tick();
        read_both("R7", 2, 15'h0000);

        // Constrained random mix with periodic full readback
        for (int blk = 0; blk < 12; blk++) begin
            for (int c = 0; c < 25; c++) begin
                int opl, opr;
                opl = $urandom_range(0, 3); opr = $urandom_range(0, 3);
                idle_l(); idle_r();
                if (opl == 1) wr_l(AW'($urandom), DW'($urandom));
                if (opl == 2) begin wr_l(AW'($urandom), DW'($urandom)); l_ce_n = 0; end
                if (opl == 3) begin wr_l(AW'($urandom), DW'($urandom)); l_sem_n = 1; end
                if (opr == 1) wr_r(AW'($urandom), DW'($urandom));
                if (opr == 2) begin wr_r(AW'($urandom), DW'($urandom)); r_ce_n = 0; end
                if (opr == 3) begin wr_r(AW'($urandom), DW'($urandom)); r_sem_n = 1; end
                tick();
            end
            idle_l(); idle_r(); tick();
            read_all("R5");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule